// File: doc/BRIEF.md
# Memory-Mapped Terminal Controller

This peripheral gives a processor access to a character terminal through four 32-bit registers reached by loads and stores. Two registers serve the input side, a status/control word and a data word, and two serve the output side. Characters arrive from the terminal side as single-cycle valid pulses carrying one byte. Outgoing characters leave on a valid/ready handshake.

Software either polls the ready flag in a control word or sets that word's interrupt-enable flag and waits for the level-sensitive interrupt line. Reading the receive data word marks the character consumed. Writing the transmit data word launches a character, but only when the transmitter is free. A receive overrun is latched on a dedicated status output and stays set until reset.

Top module: `term_mmio`

## Requirements
- R1: The register index `bus_word` selects 0 = receive control, 1 = receive data, 2 = transmit control, 3 = transmit data. Once reset has been released (two clock edges after `rst_n` rises), the reads are: receive control 0, receive data 0, transmit control 1, transmit data 0. `irq`, `tx_valid` and `rx_overrun` are all 0.
- R2: Bit 0 of each control register is the ready flag. No bus write changes it.
- R3: Receive ready becomes 1 on the edge that captures an `rx_valid` byte. It returns to 0 on the edge that completes a read of the receive data register. If an arrival and such a read coincide, ready stays 1 and the new byte is kept.
- R4: Transmit ready reads 0 from the edge that accepts a character until the edge where `tx_valid` and `tx_ready` are both 1. It reads 1 otherwise.
- R5: Each data register holds its character in bits 7:0, with bits 31:8 reading zero. The transmit data register reads back the last accepted character.
- R6: A write to the transmit data register with byte-enable bit 0 set, while transmit ready is 1, raises `tx_valid` on the next edge with `tx_byte` equal to write data bits 7:0. Both hold until the handshake completes. A write with byte-enable bit 0 clear sends nothing.
- R7: A write to the transmit data register while transmit ready is 0 is ignored: `tx_byte` and the readback are unchanged.
- R8: Bit 1 of each control register is an interrupt-enable flag. A write with byte-enable bit 0 set loads it from write data bit 1. Control bits 31:2 read zero.
- R9: `irq` is 1 exactly when (receive ready AND receive enable) OR (transmit ready AND transmit enable).
- R10: A byte arriving while receive ready is 1, and not coinciding with a receive data read, sets `rx_overrun`. The flag stays 1 until reset. The new byte still replaces the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 2 | Register index (byte offset bits 3:2) |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| rx_valid | input | 1 | Incoming character strobe |
| rx_byte | input | 8 | Incoming character |
| tx_valid | output | 1 | Outgoing character pending |
| tx_byte | output | 8 | Outgoing character |
| tx_ready | input | 1 | Terminal accepts outgoing character |
| irq | output | 1 | Level interrupt request |
| rx_overrun | output | 1 | Sticky receive overrun |

## Verification
The bench targets the cycle where an arrival coincides with a receive data read. A design that lets the read win there loses a character and clears ready. It also targets a second arrival before any read, which a design without overrun detection passes over without setting the flag. Stores to the transmit data word while a character is still pending are checked as well: a design that accepts them corrupts `tx_byte` mid-handshake. Writes of all-ones to the control words expose any design whose ready bit is writable. Stores that leave byte lane 0 disabled expose a design that sends or re-enables anyway.

// File: rtl/term_pkg.sv
`timescale 1ns/1ps
package term_pkg;
  localparam int unsigned IDX_W   = 2;
  localparam int unsigned BIT_RDY = 0;
  localparam int unsigned BIT_IE  = 1;

  typedef enum logic [IDX_W-1:0] {
    SEL_RX_CTL = 2'd0,
    SEL_RX_DAT = 2'd1,
    SEL_TX_CTL = 2'd2,
    SEL_TX_DAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/term_rst_sync.sv
`timescale 1ns/1ps
module term_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/term_rx_chan.sv
`timescale 1ns/1ps
module term_rx_chan #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_byte,
  input  logic              take_stb,
  output logic              rdy,
  output logic [CHAR_W-1:0] data,
  output logic              ovr
);
  logic              rdy_q, rdy_d;
  logic              ovr_q, ovr_d;
  logic [CHAR_W-1:0] data_q, data_d;
  logic              data_en;

  always_comb begin
    rdy_d   = rdy_q;
    ovr_d   = ovr_q;
    data_en = in_valid;
    data_d  = in_byte;
    if (in_valid) begin
      rdy_d = 1'b1;
      if (rdy_q && !take_stb) ovr_d = 1'b1;
    end else if (take_stb) begin
      rdy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign rdy  = rdy_q;
  assign data = data_q;
  assign ovr  = ovr_q;
endmodule

// File: rtl/term_tx_chan.sv
`timescale 1ns/1ps
module term_tx_chan #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CHAR_W-1:0] wr_byte,
  input  logic              out_ready,
  output logic              rdy,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_byte
);
  logic              busy_q, busy_d;
  logic [CHAR_W-1:0] byte_q;
  logic              byte_en;

  always_comb begin
    byte_en = wr_stb && !busy_q;
    busy_d  = busy_q;
    if (busy_q && out_ready) busy_d = 1'b0;
    else if (byte_en)        busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (byte_en) byte_q <= wr_byte;
  end

  assign rdy       = !busy_q;
  assign out_valid = busy_q;
  assign out_byte  = byte_q;
endmodule

// File: rtl/term_mmio.sv
`timescale 1ns/1ps
module term_mmio
  import term_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned CHAR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [1:0]           bus_word,
  input  logic [WORD_W/8-1:0]  bus_be,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  input  logic                 rx_valid,
  input  logic [CHAR_W-1:0]    rx_byte,
  output logic                 tx_valid,
  output logic [CHAR_W-1:0]    tx_byte,
  input  logic                 tx_ready,
  output logic                 irq,
  output logic                 rx_overrun
);
  localparam int unsigned BE_W = WORD_W / 8;

  logic              rst_core_n;
  logic              rd_any, wr_lo;
  logic              rx_take, tx_push;
  logic              rx_rdy, tx_rdy;
  logic [CHAR_W-1:0] rx_data;
  logic              rx_ie_q, rx_ie_d, tx_ie_q, tx_ie_d;
  logic              unused_bits;

  term_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_core_n)
  );

  assign rd_any  = bus_sel && !bus_wr;
  assign wr_lo   = bus_sel && bus_wr && bus_be[0];
  assign rx_take = rd_any && (bus_word == SEL_RX_DAT);
  assign tx_push = wr_lo  && (bus_word == SEL_TX_DAT);

  term_rx_chan #(.CHAR_W(CHAR_W)) u_rx (
    .clk(clk), .rst_n(rst_core_n), .in_valid(rx_valid), .in_byte(rx_byte),
    .take_stb(rx_take), .rdy(rx_rdy), .data(rx_data), .ovr(rx_overrun)
  );

  term_tx_chan #(.CHAR_W(CHAR_W)) u_tx (
    .clk(clk), .rst_n(rst_core_n), .wr_stb(tx_push),
    .wr_byte(bus_wdata[CHAR_W-1:0]), .out_ready(tx_ready),
    .rdy(tx_rdy), .out_valid(tx_valid), .out_byte(tx_byte)
  );

  always_comb begin
    rx_ie_d = rx_ie_q;
    tx_ie_d = tx_ie_q;
    if (wr_lo && bus_word == SEL_RX_CTL) rx_ie_d = bus_wdata[BIT_IE];
    if (wr_lo && bus_word == SEL_TX_CTL) tx_ie_d = bus_wdata[BIT_IE];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rx_ie_q <= 1'b0;
      tx_ie_q <= 1'b0;
    end else begin
      rx_ie_q <= rx_ie_d;
      tx_ie_q <= tx_ie_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (reg_sel_e'(bus_word))
      SEL_RX_CTL: begin
        bus_rdata[BIT_RDY] = rx_rdy;
        bus_rdata[BIT_IE]  = rx_ie_q;
      end
      SEL_RX_DAT: bus_rdata[CHAR_W-1:0] = rx_data;
      SEL_TX_CTL: begin
        bus_rdata[BIT_RDY] = tx_rdy;
        bus_rdata[BIT_IE]  = tx_ie_q;
      end
      SEL_TX_DAT: bus_rdata[CHAR_W-1:0] = tx_byte;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = (rx_rdy && rx_ie_q) || (tx_rdy && tx_ie_q);

  assign unused_bits = ^{bus_wdata[WORD_W-1:CHAR_W], bus_be[BE_W-1:1]};
endmodule

// File: rtl/term_mmio_chk.sv
`timescale 1ns/1ps
module term_mmio_chk #(
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [1:0]        bus_word,
  input logic              rx_valid,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [CHAR_W-1:0] tx_byte,
  input logic              irq,
  input logic              rx_overrun,
  input logic              rx_rdy,
  input logic              rx_ie,
  input logic              tx_rdy,
  input logic              tx_ie
);
  p_rx_set_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    rx_valid |=> rx_rdy);

  p_rx_clr_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_sel && !bus_wr && bus_word == 2'd1 && !rx_valid) |=> !rx_rdy);

  p_tx_busy_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    tx_valid |-> !tx_rdy);

  p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  p_tx_ignore_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tx_valid && bus_sel && bus_wr && bus_word == 2'd3) |=> $stable(tx_byte));

  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(irq) |-> ((rx_rdy && rx_ie) || (tx_rdy && tx_ie)));

  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    rx_overrun |=> rx_overrun);
endmodule

bind term_mmio term_mmio_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_word(bus_word), .rx_valid(rx_valid), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_byte(tx_byte), .irq(irq), .rx_overrun(rx_overrun),
  .rx_rdy(rx_rdy), .rx_ie(rx_ie_q), .tx_rdy(tx_rdy), .tx_ie(tx_ie_q)
);

// File: tb/term_mmio_bench.sv
`timescale 1ns/1ps
module term_mmio_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_word;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rx_valid, tx_valid, tx_ready, irq, rx_overrun;
  logic [7:0]  rx_byte, tx_byte;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model of the register state
  bit       m_rx_rdy, m_rx_ie, m_tx_ie, m_busy, m_ovr;
  bit [7:0] m_rx_dat, m_tx_byte;

  always #5 clk = ~clk;

  term_mmio u_term_mmio (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .irq(irq), .rx_overrun(rx_overrun)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [1:0] w);
    case (w)
      2'd0:    return {30'd0, m_rx_ie, m_rx_rdy};
      2'd1:    return {24'd0, m_rx_dat};
      2'd2:    return {30'd0, m_tx_ie, !m_busy};
      default: return {24'd0, m_tx_byte};
    endcase
  endfunction

  function automatic string read_tag(input logic [1:0] w);
    case (w)
      2'd0:    return "R2 R3 R8 rx control read";
      2'd1:    return "R3 R5 rx data read";
      2'd2:    return "R4 R8 tx control read";
      default: return "R5 R7 tx data read";
    endcase
  endfunction

  // one bus/device cycle, entered shortly after a rising edge
  task automatic cyc(input bit s, input bit w, input logic [1:0] a,
                     input logic [3:0] be, input logic [31:0] wd,
                     input bit rv, input logic [7:0] rb, input bit tr);
    bit take, push;
    bus_sel = s; bus_wr = w; bus_word = a; bus_be = be; bus_wdata = wd;
    rx_valid = rv; rx_byte = rb; tx_ready = tr;
    #1;
    if (s && !w) chk(bus_rdata === exp_read(a), read_tag(a), bus_rdata, exp_read(a));
    take = s && !w && a == 2'd1;
    push = s && w && be[0] && a == 2'd3 && !m_busy;
    @(posedge clk);
    if (rv) begin
      if (m_rx_rdy && !take) m_ovr = 1;
      m_rx_dat = rb; m_rx_rdy = 1;
    end else if (take) m_rx_rdy = 0;
    if (m_busy && tr) m_busy = 0;
    else if (push) begin m_busy = 1; m_tx_byte = wd[7:0]; end
    if (s && w && be[0] && a == 2'd0) m_rx_ie = wd[1];
    if (s && w && be[0] && a == 2'd2) m_tx_ie = wd[1];
    #1;
    bus_sel = 0; rx_valid = 0; tx_ready = 0;
    chk(irq === ((m_rx_rdy && m_rx_ie) || (!m_busy && m_tx_ie)), "R9 irq level",
        {31'd0, irq}, {31'd0, (m_rx_rdy && m_rx_ie) || (!m_busy && m_tx_ie)});
    chk(tx_valid === m_busy, "R4 R6 tx_valid", {31'd0, tx_valid}, {31'd0, m_busy});
    if (m_busy) chk(tx_byte === m_tx_byte, "R6 R7 tx_byte", {24'd0, tx_byte}, {24'd0, m_tx_byte});
    chk(rx_overrun === m_ovr, "R10 overrun flag", {31'd0, rx_overrun}, {31'd0, m_ovr});
  endtask

  task automatic rd(input logic [1:0] a);
    cyc(1, 0, a, 4'h0, 32'h0, 0, 8'h0, 0);
  endtask
  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    cyc(1, 1, a, be, d, 0, 8'h0, 0);
  endtask
  task automatic idle(input bit rv, input logic [7:0] rb, input bit tr);
    cyc(0, 0, 2'd0, 4'h0, 32'h0, rv, rb, tr);
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_word = 0; bus_be = 0; bus_wdata = 0;
    rx_valid = 0; rx_byte = 0; tx_ready = 0;
    m_rx_rdy = 0; m_rx_ie = 0; m_tx_ie = 0; m_busy = 0; m_ovr = 0;
    m_rx_dat = 0; m_tx_byte = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset values through every register
    chk(irq === 1'b0 && tx_valid === 1'b0 && rx_overrun === 1'b0, "R1 reset outputs",
        {29'd0, irq, tx_valid, rx_overrun}, 32'd0);
    bus_sel = 1; bus_wr = 0;
    for (int i = 0; i < 4; i++) begin
      bus_word = 2'(i); #1;
      chk(bus_rdata === (i == 2 ? 32'd1 : 32'd0), "R1 reset register", bus_rdata,
          (i == 2 ? 32'd1 : 32'd0));
    end
    bus_sel = 0;
    @(posedge clk); #1;

    // R2 R8: all-ones into control words, ready bits unaffected
    wr(2'd0, 4'hF, 32'hFFFF_FFFF); rd(2'd0);
    wr(2'd2, 4'hF, 32'hFFFF_FFFC); rd(2'd2);
    wr(2'd2, 4'hE, 32'h0000_0002); rd(2'd2);   // lane 0 off: no change (R8)
    wr(2'd0, 4'hF, 32'h0);         rd(2'd0);
    wr(2'd2, 4'hF, 32'h0);

    // R3 R9: arrival, interrupt, consumption
    wr(2'd0, 4'h1, 32'h2);
    idle(1, 8'hA5, 0); rd(2'd0); rd(2'd1); rd(2'd0);
    // R10: second arrival before any read
    idle(1, 8'h11, 0); idle(1, 8'h22, 0); rd(2'd1); rd(2'd0);
    // R3: arrival coinciding with a data read keeps the new byte
    idle(1, 8'h33, 0);
    cyc(1, 0, 2'd1, 4'h0, 32'h0, 1, 8'h44, 0);
    rd(2'd0); rd(2'd1);

    // R6 R7 R4: transmit path
    wr(2'd2, 4'h1, 32'h2);
    wr(2'd3, 4'hE, 32'h0000_0077);             // lane 0 off: nothing sent
    wr(2'd3, 4'h1, 32'hFFFF_FF3C);
    rd(2'd2);
    wr(2'd3, 4'hF, 32'h0000_0055);             // ignored while busy
    idle(0, 8'h0, 0); rd(2'd3);
    cyc(1, 1, 2'd3, 4'hF, 32'h66, 0, 8'h0, 1); // handshake and write together
    rd(2'd2); rd(2'd3);

    // constrained random mix
    for (int k = 0; k < 3000; k++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1: idle(1, 8'($urandom), $urandom_range(0, 1) == 1);
        2:    rd(2'd1);
        3:    rd(2'($urandom_range(0, 3)));
        4:    wr(2'd0, 4'($urandom), $urandom);
        5:    wr(2'd2, 4'($urandom), $urandom);
        6, 7: cyc(1, 1, 2'd3, 4'($urandom), $urandom, $urandom_range(0, 3) == 0,
                  8'($urandom), $urandom_range(0, 1) == 1);
        8:    cyc(1, 0, 2'd1, 4'h0, 32'h0, 1, 8'($urandom), 0);
        default: idle(0, 8'h0, $urandom_range(0, 2) == 0);
      endcase
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule